// File: doc/BRIEF.md
# Timed Unlock Gate for Protected Configuration Writes

This block guards a small set of critical configuration registers, such as clock selection and watchdog controls, against stray writes. It sits between a simple single-cycle register write bus and the register file. It turns each bus write into a registered write-enable strobe for the selected register. Writes to addresses on a parameter list of protected registers are only let through when software has just unlocked the gate. Runaway code or a corrupted pointer that happens to hit a protected address is therefore dropped.

To unlock, software writes one specific key value to a dedicated unlock address. This arms a countdown of `WINDOW` cycles. A protected write presented in any of those cycles is forwarded, and it also closes the gate at once. A protected write presented outside an armed window is discarded without any trace. Writes to ordinary addresses are always forwarded, and they leave the countdown untouched. Writing any value other than the key to the unlock address disarms the gate.

Top module: `cfg_write_guard`

## Requirements
- R1: After reset, `prot_we` and `plain_we` are low and `window_open` is low.
- R2: A bus write of `KEY_VALUE` to `KEY_ADDR` arms the gate. A protected write presented in any of the `WINDOW` cycles that follow that key write is forwarded.
- R3: A protected write presented when no key write occurred within the previous `WINDOW` cycles is dropped: `prot_we` stays all zero.
- R4: A write of any value other than `KEY_VALUE` to `KEY_ADDR` leaves the gate disarmed, and it disarms an armed gate. A following protected write is dropped.
- R5: The first forwarded protected write closes the gate. A second protected write in the same window is dropped.
- R6: A write to an address that is neither `KEY_ADDR` nor protected raises `plain_we` one cycle later, whether the gate is armed or not. It neither closes nor extends the window.
- R7: A forwarded protected write to the address in entry i of `PROT_ADDRS` raises bit i of `prot_we`, and only that bit, for one cycle. Entry 0 sits in the least significant `ADDR_W` bits. `out_addr` and `out_wdata` carry that write's address and data in the same cycle. With the default list, bits 0, 1 and 2 belong to 0x08, 0x11 and 0x22.
- R8: A write to `KEY_ADDR` raises no strobe, whatever its value.
- R9: A correct key write while the gate is armed restarts the countdown at a full `WINDOW` cycles.
- R10: After a correct key write followed by k cycles with no bus write, `window_open` is high if k < `WINDOW` and low otherwise.
- R11: At most one strobe among `prot_we` and `plain_we` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write valid for this cycle |
| bus_addr | input | ADDR_W | Bus write address |
| bus_wdata | input | DATA_W | Bus write data |
| prot_we | output | NUM_PROT | One write strobe per protected register, entry order of `PROT_ADDRS` |
| plain_we | output | 1 | Write strobe for an unprotected register |
| out_addr | output | ADDR_W | Address of the write being strobed |
| out_wdata | output | DATA_W | Data of the write being strobed |
| window_open | output | 1 | High while the gate is armed |

## Verification
Every strobe, together with `out_addr` and `out_wdata`, appears in the cycle after the edge that samples the bus write. `window_open` reflects a key write from that same following cycle. The bench drives each write on a falling edge and reads the outputs 1 ns after the rising edge that samples it, so each result is compared exactly in the cycle it is due. For the window sweeps, the bench counts the idle edges between the key write and the protected write itself. It predicts acceptance arithmetically as "gap + 1 ≤ WINDOW".

// File: rtl/cwg_pkg.sv
package cwg_pkg;

  // Next value of the unlock countdown: a correct key reloads it, a wrong key
  // or a consumed window clears it, otherwise it runs down to zero.
  function automatic int unsigned next_count(int unsigned cur, logic arm,
                                             logic kill, int unsigned load);
    if (arm)      return load;
    if (kill)     return 0;
    if (cur != 0) return cur - 1;
    return 0;
  endfunction

  // True when a write carries the exact unlock key.
  function automatic logic key_matches(logic [63:0] data, logic [63:0] key);
    return data == key;
  endfunction

endpackage

// File: rtl/cwg_addr_match.sv
module cwg_addr_match #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_PROT = 3,
  parameter logic [NUM_PROT*ADDR_W-1:0] PROT_ADDRS = {8'h22, 8'h11, 8'h08},
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hF0
) (
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_PROT-1:0] prot_hit,
  output logic                key_hit,
  output logic                plain_hit
);

  logic any_prot;

  for (genvar i = 0; i < NUM_PROT; i++) begin : g_cmp
    assign prot_hit[i] = wr && (addr == PROT_ADDRS[i*ADDR_W +: ADDR_W]);
  end

  assign any_prot  = |prot_hit;
  assign key_hit   = wr && (addr == KEY_ADDR);
  assign plain_hit = wr && !any_prot && !key_hit;

endmodule

// File: rtl/cwg_window_timer.sv
module cwg_window_timer #(
  parameter int unsigned WINDOW = 4,
  localparam int unsigned CNT_W = $clog2(WINDOW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             disarm,
  input  logic             consume,
  output logic             open,
  output logic [CNT_W-1:0] cnt_q
);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = CNT_W'(cwg_pkg::next_count(32'(cnt_q), arm, disarm | consume, WINDOW));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign open = (cnt_q != '0);

endmodule

// File: rtl/cwg_strobe_reg.sv
module cwg_strobe_reg #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_PROT = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PROT-1:0] grant,
  input  logic                plain_go,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [NUM_PROT-1:0] prot_we,
  output logic                plain_we,
  output logic [ADDR_W-1:0]   out_addr,
  output logic [DATA_W-1:0]   out_wdata
);

  logic fwd;
  assign fwd = plain_go | (|grant);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_we  <= '0;
      plain_we <= 1'b0;
    end else begin
      prot_we  <= grant;
      plain_we <= plain_go;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_addr  <= '0;
      out_wdata <= '0;
    end else if (fwd) begin
      out_addr  <= addr;
      out_wdata <= wdata;
    end
  end

endmodule

// File: rtl/cfg_write_guard.sv
module cfg_write_guard #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_PROT = 3,
  parameter logic [NUM_PROT*ADDR_W-1:0] PROT_ADDRS = {8'h22, 8'h11, 8'h08},
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'hF0,
  parameter logic [DATA_W-1:0] KEY_VALUE = 8'hC3,
  parameter int unsigned WINDOW   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [NUM_PROT-1:0] prot_we,
  output logic                plain_we,
  output logic [ADDR_W-1:0]   out_addr,
  output logic [DATA_W-1:0]   out_wdata,
  output logic                window_open
);

  localparam int unsigned CNT_W = $clog2(WINDOW + 1);

  // Named internal events, also watched by the bound checker.
  logic [NUM_PROT-1:0] prot_hit;
  logic                key_hit;
  logic                plain_hit;
  logic                key_ok;
  logic                key_bad;
  logic                prot_req;
  logic                prot_accept;
  logic [NUM_PROT-1:0] grant;
  logic                win_open;
  logic [CNT_W-1:0]    win_cnt;

  cwg_addr_match #(
    .ADDR_W    (ADDR_W),
    .NUM_PROT  (NUM_PROT),
    .PROT_ADDRS(PROT_ADDRS),
    .KEY_ADDR  (KEY_ADDR)
  ) u_match (
    .wr       (bus_wr),
    .addr     (bus_addr),
    .prot_hit (prot_hit),
    .key_hit  (key_hit),
    .plain_hit(plain_hit)
  );

  assign key_ok      = key_hit && cwg_pkg::key_matches(64'(bus_wdata), 64'(KEY_VALUE));
  assign key_bad     = key_hit && !key_ok;
  assign prot_req    = |prot_hit;
  assign prot_accept = prot_req && win_open;
  assign grant       = prot_hit & {NUM_PROT{win_open}};

  cwg_window_timer #(
    .WINDOW(WINDOW)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (key_ok),
    .disarm (key_bad),
    .consume(prot_accept),
    .open   (win_open),
    .cnt_q  (win_cnt)
  );

  cwg_strobe_reg #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_PROT(NUM_PROT)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant    (grant),
    .plain_go (plain_hit),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .prot_we  (prot_we),
    .plain_we (plain_we),
    .out_addr (out_addr),
    .out_wdata(out_wdata)
  );

  assign window_open = win_open;

endmodule

// File: rtl/cwg_checker.sv
module cwg_checker #(
  parameter int unsigned NUM_PROT = 3,
  parameter int unsigned WINDOW   = 4,
  parameter int unsigned CNT_W    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                key_ok,
  input logic                key_bad,
  input logic                key_hit,
  input logic                prot_req,
  input logic                plain_hit,
  input logic [CNT_W-1:0]    win_cnt,
  input logic                window_open,
  input logic [NUM_PROT-1:0] prot_we,
  input logic                plain_we
);

  localparam int unsigned RUN_W = $clog2(WINDOW + 2) + 1;
  logic [RUN_W-1:0] run;

  // Counts how many cycles the window has been open since the last arm.
  always_ff @(posedge clk) begin
    if (!rst_n)           run <= '0;
    else if (key_ok)      run <= RUN_W'(1);
    else if (window_open) run <= run + RUN_W'(1);
    else                  run <= '0;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (prot_we == '0) && !plain_we && !window_open);

  p_key_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    key_ok |=> window_open);

  p_locked_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_req && !window_open) |=> (prot_we == '0));

  p_bad_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    key_bad |=> !window_open);

  p_close_on_use_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_we != '0) |-> !window_open);

  p_plain_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    plain_hit |=> plain_we);

  p_plain_keeps_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_hit && win_cnt > CNT_W'(1)) |=> window_open);

  p_key_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> (prot_we == '0) && !plain_we);

  p_window_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    window_open |-> (run >= RUN_W'(1)) && (run <= RUN_W'(WINDOW)));

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prot_we, plain_we}));

endmodule

bind cfg_write_guard cwg_checker #(
  .NUM_PROT(NUM_PROT),
  .WINDOW  (WINDOW),
  .CNT_W   ($clog2(WINDOW + 1))
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .key_ok     (key_ok),
  .key_bad    (key_bad),
  .key_hit    (key_hit),
  .prot_req   (prot_req),
  .plain_hit  (plain_hit),
  .win_cnt    (win_cnt),
  .window_open(window_open),
  .prot_we    (prot_we),
  .plain_we   (plain_we)
);

// File: tb/tb_cfg_write_guard.sv
`timescale 1ns/1ps
module tb_cfg_write_guard;

  localparam int unsigned AW = 8;
  localparam int unsigned DW = 8;
  localparam int unsigned NP = 3;
  localparam int unsigned WIN = 4;
  localparam logic [AW-1:0] KADDR = 8'hF0;
  localparam logic [DW-1:0] KVAL  = 8'hC3;
  localparam logic [AW-1:0] PA [NP] = '{8'h08, 8'h11, 8'h22};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [NP-1:0] prot_we;
  logic plain_we;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_wdata;
  logic window_open;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cfg_write_guard #(
    .ADDR_W(AW), .DATA_W(DW), .NUM_PROT(NP),
    .PROT_ADDRS({8'h22, 8'h11, 8'h08}),
    .KEY_ADDR(KADDR), .KEY_VALUE(KVAL), .WINDOW(WIN)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .prot_we(prot_we), .plain_we(plain_we),
    .out_addr(out_addr), .out_wdata(out_wdata), .window_open(window_open)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One bus write, sampled at the next rising edge; outputs read 1 ns later.
  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  function automatic bit is_prot(logic [AW-1:0] a);
    for (int i = 0; i < NP; i++) if (PA[i] == a) return 1;
    return 0;
  endfunction

  initial begin
    #3_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 prot_we", 32'(prot_we), 0);
    check("R1 plain_we", 32'(plain_we), 0);
    check("R1 window_open", 32'(window_open), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(1);

    // R2 / R3 / R7 / R8 / R5: gap sweep for every protected entry.
    for (int i = 0; i < NP; i++) begin
      for (int d = 0; d <= WIN + 2; d++) begin
        logic [DW-1:0] v;
        bit acc;
        v = DW'(8'h10 * i + d + 1);
        acc = (d + 1 <= WIN);
        wr(KADDR, KVAL);
        check("R8 key no strobe", 32'({prot_we, plain_we}), 0);
        check("R10 open after key", 32'(window_open), 1);
        idle(d);
        wr(PA[i], v);
        check(acc ? "R2 accepted in window" : "R3 dropped late",
              32'(prot_we), acc ? 32'(1 << i) : 0);
        if (acc) begin
          check("R7 addr", 32'(out_addr), 32'(PA[i]));
          check("R7 data", 32'(out_wdata), 32'(v));
          check("R5 closed after use", 32'(window_open), 0);
          wr(PA[(i + 1) % NP], 8'h77);
          check("R5 second write dropped", 32'(prot_we), 0);
        end
        idle(WIN + 1);
      end
    end

    // R3: protected writes with no key at all.
    for (int i = 0; i < NP; i++) begin
      wr(PA[i], 8'h5A);
      check("R3 no key", 32'(prot_we), 0);
    end

    // R4 / R2: every value written to the key address.
    for (int v = 0; v < 256; v++) begin
      wr(KADDR, DW'(v));
      check("R8 key any value", 32'({prot_we, plain_we}), 0);
      check("R4 arm only on key", 32'(window_open), (v == KVAL) ? 1 : 0);
      wr(PA[0], 8'h33);
      check("R4 gate follows key", 32'(prot_we), (v == KVAL) ? 1 : 0);
      idle(WIN + 1);
    end

    // R4: wrong key disarms an armed gate.
    wr(KADDR, KVAL);
    wr(KADDR, KVAL ^ 8'h01);
    check("R4 disarmed", 32'(window_open), 0);
    wr(PA[1], 8'h44);
    check("R4 dropped after bad key", 32'(prot_we), 0);
    idle(WIN + 1);

    // R6: plain address sweep with gate closed.
    for (int a = 0; a < 256; a++) begin
      bit pl;
      pl = !is_prot(AW'(a)) && (AW'(a) != KADDR);
      wr(AW'(a), DW'(a) ^ 8'h5A);
      check("R6 plain strobe", 32'(plain_we), pl ? 1 : 0);
      check("R11 no prot strobe", 32'(prot_we), 0);
      if (pl) check("R6 plain data", 32'(out_wdata), 32'(DW'(a) ^ 8'h5A));
    end
    idle(WIN + 1);

    // R6: plain writes inside the window neither close nor extend it.
    for (int n = 0; n <= WIN; n++) begin
      wr(KADDR, KVAL);
      for (int k = 0; k < n; k++) begin
        wr(8'h60, DW'(k));
        check("R6 plain in window", 32'(plain_we), 1);
      end
      wr(PA[2], 8'h99);
      check("R6 window unchanged by plain", 32'(prot_we), (n + 1 <= WIN) ? 32'(4) : 0);
      idle(WIN + 1);
    end

    // R9: second key reloads the countdown.
    wr(KADDR, KVAL);
    idle(2);
    wr(KADDR, KVAL);
    idle(2);
    wr(PA[1], 8'hA5);
    check("R9 reload", 32'(prot_we), 2);
    idle(WIN + 1);

    // R10: window_open over idle cycles.
    for (int k = 0; k <= WIN + 1; k++) begin
      wr(KADDR, KVAL);
      idle(k);
      check("R10 window_open", 32'(window_open), (k < WIN) ? 1 : 0);
      idle(WIN + 1);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule